// File: doc/BRIEF.md
# Fixed-Priority Dual-Requester Memory Arbiter

This block lets two masters share one single-port memory. Each master speaks the same valid/ready request protocol: it raises valid with an address, write data and a byte strobe, holds them steady, and the transfer finishes in the cycle where ready is high together with valid. A strobe of all zeros is a read. The values 0001, 0011, 0111 and 1111 write the lowest 1, 2, 3 or 4 bytes.

The high-priority port is meant for a device's DMA engine, and the low-priority port is meant for the processor. When no transfer is pending, the request is chosen combinationally. A lone requester therefore reaches the memory in the same cycle it raises valid. When both requesters ask at once, the high-priority port wins. If the memory does not answer in that cycle, the chosen requester is locked in until the memory's ready completes the transfer. A later high-priority request cannot take the port away during that time.

Ready goes back only to the requester that owns the transfer, and read data is passed only to that requester. The low-priority port can wait for as long as the high-priority port keeps requesting.

Top module: `fp_mem_arbiter`

## Requirements
- R1: With no transfer pending, a lone valid requester (either port) drives the memory port in the same cycle: mem_valid is 1 and mem_addr, mem_wdata and mem_wstrb equal that requester's values.
- R2: With no transfer pending and both ports valid, the high-priority port is forwarded and the low-priority ready stays 0.
- R3: Once a forwarded transfer sees mem_ready at 0, the same requester stays forwarded on later cycles until mem_ready is 1. A high-priority request that arrives in the meantime does not take over.
- R4: At most one requester ready is 1 in any cycle. A requester's ready is 1 only when mem_valid and mem_ready are both 1 and that requester owns the transfer.
- R5: The owning requester's read data equals mem_rdata. The read data of the other requester is driven to zero.
- R6: When no requester is valid and none is locked in, mem_valid is 0, mem_wstrb is 0000, and mem_addr and mem_wdata are zero.
- R7: After a transfer completes, no idle cycle follows. In the next cycle, a waiting requester is forwarded at once.
- R8: mem_wstrb passes through unchanged. With the bench memory, 0000 reads, and 0001, 0011, 0111 and 1111 write the lowest 1, 2, 3 and 4 bytes.
- R9: While rst_n is low, mem_valid and both requester readies are 0, whatever the inputs are.
- R10: While the high-priority port stays valid, the low-priority port gets no ready, even on cycles where the memory completes transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hi_valid | input | 1 | High-priority request valid |
| hi_ready | output | 1 | High-priority transfer complete |
| hi_addr | input | 32 | High-priority address |
| hi_wdata | input | 32 | High-priority write data |
| hi_wstrb | input | 4 | High-priority byte strobe (0000 = read) |
| hi_rdata | output | 32 | High-priority read data |
| lo_valid | input | 1 | Low-priority request valid |
| lo_ready | output | 1 | Low-priority transfer complete |
| lo_addr | input | 32 | Low-priority address |
| lo_wdata | input | 32 | Low-priority write data |
| lo_wstrb | input | 4 | Low-priority byte strobe (0000 = read) |
| lo_rdata | output | 32 | Low-priority read data |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory transfer complete |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_wstrb | output | 4 | Memory byte strobe |
| mem_rdata | input | 32 | Memory read data |

## Verification
A vector table covers every combination of the two valid inputs, with the memory answering at once and with the memory stalling. This separates plain priority selection from lock-in: a stalled low-priority transfer that is later joined by a high-priority request must still complete on the low-priority port. Directed sequences then write through all four strobe widths into a bench memory and read the results back on both ports. This exposes byte-lane mistakes and read data leaking to the wrong port. A back-to-back hand-over checks that the waiting port is forwarded in the very next cycle. A sustained high-priority stream shows that the low-priority port stays stalled.

// File: rtl/arb_pkg.sv
// Shared types for the fixed-priority memory arbiter.
// Assumes: exactly two requesters, identified by a one-bit source code.
package arb_pkg;
    typedef enum logic {
        SRC_HI = 1'b0,
        SRC_LO = 1'b1
    } src_e;
endpackage

// File: rtl/arb_grant.sv
// Grant controller: picks the requester to forward and locks it in while
// the memory stalls the transfer.
// Assumes: requesters keep valid and payload stable until their ready.
module arb_grant
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hi_valid,
    input  logic lo_valid,
    input  logic mem_ready,
    output src_e sel,
    output logic active,
    output logic locked,
    output src_e lock_src
);
    logic locked_q;
    src_e lock_src_q;

    // Purpose: choose the source, held while locked, else by fixed priority.
    always_comb begin
        if (!rst_n) begin
            sel    = SRC_HI;
            active = 1'b0;
        end else if (locked_q) begin
            sel    = lock_src_q;
            active = (lock_src_q == SRC_HI) ? hi_valid : lo_valid;
        end else begin
            sel    = hi_valid ? SRC_HI : SRC_LO;
            active = hi_valid | lo_valid;
        end
    end

    // Purpose: record the owner of a stalled transfer, release on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q   <= 1'b0;
            lock_src_q <= SRC_HI;
        end else if (active && !mem_ready) begin
            locked_q   <= 1'b1;
            lock_src_q <= sel;
        end else begin
            locked_q   <= 1'b0;
        end
    end

    assign locked   = locked_q;
    assign lock_src = lock_src_q;
endmodule

// File: rtl/arb_fwd.sv
// Request path: steers the selected requester's payload to the memory port.
// Assumes: sel and active come from the grant controller in the same cycle.
module arb_fwd
    import arb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int STRB_W = DATA_W / 8
) (
    input  src_e              sel,
    input  logic              active,
    input  logic [ADDR_W-1:0] hi_addr,
    input  logic [DATA_W-1:0] hi_wdata,
    input  logic [STRB_W-1:0] hi_wstrb,
    input  logic [ADDR_W-1:0] lo_addr,
    input  logic [DATA_W-1:0] lo_wdata,
    input  logic [STRB_W-1:0] lo_wstrb,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [STRB_W-1:0] mem_wstrb
);
    // Purpose: forward the granted payload, or all zeros while idle.
    always_comb begin
        mem_valid = active;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_wstrb = '0;
        if (active) begin
            if (sel == SRC_HI) begin
                mem_addr  = hi_addr;
                mem_wdata = hi_wdata;
                mem_wstrb = hi_wstrb;
            end else begin
                mem_addr  = lo_addr;
                mem_wdata = lo_wdata;
                mem_wstrb = lo_wstrb;
            end
        end
    end
endmodule

// File: rtl/arb_resp.sv
// Response path: routes the memory's ready and read data to the owner only.
// Assumes: the non-owner ignores its read data; it is driven to zero.
module arb_resp
    import arb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  src_e              sel,
    input  logic              active,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              hi_ready,
    output logic [DATA_W-1:0] hi_rdata,
    output logic              lo_ready,
    output logic [DATA_W-1:0] lo_rdata
);
    logic own_hi;
    logic own_lo;

    // Purpose: decode which requester owns the forwarded transfer.
    always_comb begin
        own_hi = active && (sel == SRC_HI);
        own_lo = active && (sel == SRC_LO);
    end

    // Purpose: return completion and read data to the owner, zero elsewhere.
    always_comb begin
        hi_ready = own_hi && mem_ready;
        lo_ready = own_lo && mem_ready;
        hi_rdata = own_hi ? mem_rdata : '0;
        lo_rdata = own_lo ? mem_rdata : '0;
    end
endmodule

// File: rtl/fp_mem_arbiter.sv
// Top: two valid/ready requesters share one single-port memory. The
// high-priority port wins ties; a stalled transfer keeps its grant.
// Assumes: each requester holds valid and payload until its ready.
module fp_mem_arbiter
    import arb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_valid,
    output logic              hi_ready,
    input  logic [ADDR_W-1:0] hi_addr,
    input  logic [DATA_W-1:0] hi_wdata,
    input  logic [DATA_W/8-1:0] hi_wstrb,
    output logic [DATA_W-1:0] hi_rdata,
    input  logic              lo_valid,
    output logic              lo_ready,
    input  logic [ADDR_W-1:0] lo_addr,
    input  logic [DATA_W-1:0] lo_wdata,
    input  logic [DATA_W/8-1:0] lo_wstrb,
    output logic [DATA_W-1:0] lo_rdata,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W/8-1:0] mem_wstrb,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int STRB_W = DATA_W / 8;

    src_e sel;
    logic active;
    logic lock_q;
    src_e lock_src_q;

    arb_grant u_grant (
        .clk       (clk),
        .rst_n     (rst_n),
        .hi_valid  (hi_valid),
        .lo_valid  (lo_valid),
        .mem_ready (mem_ready),
        .sel       (sel),
        .active    (active),
        .locked    (lock_q),
        .lock_src  (lock_src_q)
    );

    arb_fwd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STRB_W(STRB_W)) u_fwd (
        .sel       (sel),
        .active    (active),
        .hi_addr   (hi_addr),
        .hi_wdata  (hi_wdata),
        .hi_wstrb  (hi_wstrb),
        .lo_addr   (lo_addr),
        .lo_wdata  (lo_wdata),
        .lo_wstrb  (lo_wstrb),
        .mem_valid (mem_valid),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_wstrb (mem_wstrb)
    );

    arb_resp #(.DATA_W(DATA_W)) u_resp (
        .sel       (sel),
        .active    (active),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .hi_ready  (hi_ready),
        .hi_rdata  (hi_rdata),
        .lo_ready  (lo_ready),
        .lo_rdata  (lo_rdata)
    );
endmodule

// File: rtl/arb_checker.sv
// Protocol and priority assertions for fp_mem_arbiter, attached by bind.
module arb_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hi_valid,
    input logic              lo_valid,
    input logic [ADDR_W-1:0] hi_addr,
    input logic [ADDR_W-1:0] lo_addr,
    input logic              hi_ready,
    input logic              lo_ready,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W/8-1:0] mem_wstrb,
    input logic              locked,
    input logic              lock_is_lo,
    input logic              sel_is_lo
);
    a_r1_lone_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && lo_valid && !hi_valid) |-> (mem_valid && mem_addr == lo_addr));
    a_r1_lone_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && hi_valid && !lo_valid) |-> (mem_valid && mem_addr == hi_addr));
    a_r2_hi_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && hi_valid && lo_valid) |-> (mem_addr == hi_addr && !lo_ready));
    a_r3_hold_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (locked && lock_is_lo == $past(sel_is_lo)));
    a_r4_one_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hi_ready, lo_ready}));
    a_r4_ready_source: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_ready || lo_ready) |-> (mem_valid && mem_ready));
    a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !hi_valid && !lo_valid) |-> (!mem_valid && mem_wstrb == '0));
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready) |=> !locked);
    a_r9_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!mem_valid && !hi_ready && !lo_ready));
endmodule

bind fp_mem_arbiter arb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hi_valid   (hi_valid),
    .lo_valid   (lo_valid),
    .hi_addr    (hi_addr),
    .lo_addr    (lo_addr),
    .hi_ready   (hi_ready),
    .lo_ready   (lo_ready),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_addr   (mem_addr),
    .mem_wstrb  (mem_wstrb),
    .locked     (lock_q),
    .lock_is_lo (lock_src_q == arb_pkg::SRC_LO),
    .sel_is_lo  (sel == arb_pkg::SRC_LO)
);

// File: tb/test_fp_mem_arbiter.sv
`timescale 1ns/1ps
module test_fp_mem_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hi_valid = 1'b0, lo_valid = 1'b0;
    logic        hi_ready, lo_ready;
    logic [31:0] hi_addr = '0, lo_addr = '0, hi_wdata = '0, lo_wdata = '0;
    logic [3:0]  hi_wstrb = '0, lo_wstrb = '0;
    logic [31:0] hi_rdata, lo_rdata;
    logic        mem_valid;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_wstrb;
    logic [31:0] ram [16];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fp_mem_arbiter i_fp_mem_arbiter (
        .clk(clk), .rst_n(rst_n),
        .hi_valid(hi_valid), .hi_ready(hi_ready), .hi_addr(hi_addr),
        .hi_wdata(hi_wdata), .hi_wstrb(hi_wstrb), .hi_rdata(hi_rdata),
        .lo_valid(lo_valid), .lo_ready(lo_ready), .lo_addr(lo_addr),
        .lo_wdata(lo_wdata), .lo_wstrb(lo_wstrb), .lo_rdata(lo_rdata),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb), .mem_rdata(mem_rdata)
    );

    // Behavioural single-port memory: word index from address bits 5:2.
    assign mem_rdata = ram[mem_addr[5:2]];
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) ram[i] <= '0;
        end else if (mem_valid && mem_ready) begin
            for (int b = 0; b < 4; b++)
                if (mem_wstrb[b]) ram[mem_addr[5:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Vector: [7]hi_valid [6]lo_valid [5]mem_ready [4]exp mem_valid
    //         [3]exp hi_ready [2]exp lo_ready [1:0]exp source 0 none 1 hi 2 lo
    localparam logic [7:0] VEC [8] = '{
        8'b000_000_00,  // idle (R6)
        8'b101_110_01,  // lone hi (R1)
        8'b011_101_10,  // lone lo (R1)
        8'b111_110_01,  // both, hi wins (R2)
        8'b100_100_01,  // hi stalled
        8'b101_110_01,  // hi completes after stall (R3)
        8'b010_100_10,  // lo stalled, locks lo
        8'b111_101_10   // hi arrives, lo keeps grant (R3)
    };

    initial begin
        hi_addr = 32'h100; hi_wdata = 32'hA5A5_0001; hi_wstrb = 4'hF;
        lo_addr = 32'h200; lo_wdata = 32'h5A5A_0002; lo_wstrb = 4'h1;
        // R9: reset keeps the memory port and readies quiet.
        hi_valid = 1'b1; lo_valid = 1'b1; mem_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk("R9 mem_valid", {31'b0, mem_valid}, 0);
        chk("R9 hi_ready", {31'b0, hi_ready}, 0);
        chk("R9 lo_ready", {31'b0, lo_ready}, 0);
        hi_valid = 1'b0; lo_valid = 1'b0; mem_ready = 1'b0;
        @(negedge clk); rst_n = 1'b1;

        // Vector table walk.
        for (int i = 0; i < 8; i++) begin
            logic [31:0] ea;
            logic [3:0]  es;
            @(negedge clk);
            hi_valid = VEC[i][7]; lo_valid = VEC[i][6]; mem_ready = VEC[i][5];
            #1;
            ea = (VEC[i][1:0] == 2'd1) ? 32'h100 : (VEC[i][1:0] == 2'd2) ? 32'h200 : 32'h0;
            es = (VEC[i][1:0] == 2'd1) ? 4'hF : (VEC[i][1:0] == 2'd2) ? 4'h1 : 4'h0;
            chk($sformatf("R1/R2/R3 vec%0d mem_valid", i), {31'b0, mem_valid}, {31'b0, VEC[i][4]});
            chk($sformatf("R1/R2/R3 vec%0d mem_addr", i), mem_addr, ea);
            chk($sformatf("R6/R8 vec%0d mem_wstrb", i), {28'b0, mem_wstrb}, {28'b0, es});
            chk($sformatf("R4 vec%0d hi_ready", i), {31'b0, hi_ready}, {31'b0, VEC[i][3]});
            chk($sformatf("R4 vec%0d lo_ready", i), {31'b0, lo_ready}, {31'b0, VEC[i][2]});
        end
        @(negedge clk); hi_valid = 1'b0; lo_valid = 1'b0; mem_ready = 1'b0; #1;
        chk("R6 idle wdata", mem_wdata, 0);
        chk("R6 idle addr", mem_addr, 0);

        // R8/R5: strobe widths written into word 3, read back per port.
        mem_ready = 1'b1;
        hi_valid = 1'b1; hi_addr = 32'h0C; hi_wdata = 32'hAABB_CCDD; hi_wstrb = 4'hF;
        @(negedge clk); hi_valid = 1'b0;
        lo_valid = 1'b1; lo_addr = 32'h0C; lo_wdata = 32'h0000_0011; lo_wstrb = 4'b0001;
        #1; chk("R1 lo wdata forwarded", mem_wdata, 32'h11);
        @(negedge clk); lo_wstrb = 4'b0000; #1;
        chk("R8 1-byte write", lo_rdata, 32'hAABB_CC11);
        chk("R5 hi_rdata zero for non-owner", hi_rdata, 0);
        @(negedge clk); lo_wdata = 32'h0000_2222; lo_wstrb = 4'b0011;
        @(negedge clk); lo_valid = 1'b0;
        hi_valid = 1'b1; hi_wstrb = 4'b0000; #1;
        chk("R8 2-byte write", hi_rdata, 32'hAABB_2222);
        chk("R5 lo_rdata zero for non-owner", lo_rdata, 0);
        hi_wdata = 32'h0033_3333; hi_wstrb = 4'b0111;
        @(negedge clk); hi_wstrb = 4'b0000; #1;
        chk("R8 3-byte write", hi_rdata, 32'hAA33_3333);
        chk("R8 read strobe", {28'b0, mem_wstrb}, 0);

        // R3/R7: stalled lo transfer, hi joins, then hand-over with no gap.
        @(negedge clk); hi_valid = 1'b0; mem_ready = 1'b0;
        lo_valid = 1'b1; lo_addr = 32'h20; lo_wstrb = 4'b0000;
        @(negedge clk); hi_valid = 1'b1; hi_addr = 32'h24; #1;
        chk("R3 lo keeps grant", mem_addr, 32'h20);
        chk("R3 hi_ready low", {31'b0, hi_ready}, 0);
        @(negedge clk); #1;
        chk("R3 still lo after 2 stall cycles", mem_addr, 32'h20);
        mem_ready = 1'b1; #1;
        chk("R4 lo completes", {31'b0, lo_ready}, 1);
        @(negedge clk); lo_valid = 1'b0; #1;
        chk("R7 hi forwarded next cycle", mem_addr, 32'h24);
        chk("R7 hi_ready next cycle", {31'b0, hi_ready}, 1);

        // R10: lo waits for as long as hi keeps requesting.
        lo_valid = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); #1;
            chk("R10 lo starved", {31'b0, lo_ready}, 0);
            chk("R10 hi served", {31'b0, hi_ready}, 1);
        end
        @(negedge clk); hi_valid = 1'b0; #1;
        chk("R10 lo served once hi idles", {31'b0, lo_ready}, 1);
        @(negedge clk); lo_valid = 1'b0; mem_ready = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule